// File: doc/BRIEF.md
# Delayed Adjacent-Pixel Coincidence Trigger

This block watches a stream of timestamped particle hits from a hexagonal detector of 127 pixels and pairs fast electrons with the slower protons that follow them. Each electron hit is held in a small pending store. A later proton hit is paired with a stored electron when it lands on the same pixel or one of that pixel's six hexagonal neighbours, and when its delay falls inside a window that opens 12 µs and closes 40 µs after the electron. Timestamps count 10 ns ticks, so the window runs from 1200 to 4000 ticks.

Every hit with a legal pixel index is also reported at once as a single-particle trigger, separate from the pairing decision. A matched pair is reported with both pixel indices and the time of flight. Electrons older than the window are retired, and a full store makes room by discarding its oldest entry. An overflow counter records each discard.

The block accepts one hit per clock. All outputs are registered and appear on the clock edge after the hit is presented. Hit timestamps must not decrease from one hit to the next.

Top module: `coinc_trigger`

## Requirements
- R1: A hit with `hit_valid` high and a pixel index below 127 gives, one clock later, `single_valid` high, with `single_pixel` and `single_is_proton` equal to that hit's pixel and class (`hit_is_proton` = 1 means proton, 0 means electron).
- R2: A hit with a pixel index of 127 or above is ignored: it raises neither `single_valid` nor `coinc_valid`, it is not stored, and it retires nothing.
- R3: A proton hit whose timestamp minus a stored electron's timestamp is between 1200 and 4000 ticks inclusive, on a matching pixel, gives `coinc_valid` one clock later. `coinc_e_pixel` and `coinc_p_pixel` carry the two pixel indices, and `coinc_tof` carries the difference as a 12-bit tick count.
- R4: A delay of 1199 ticks or less, or of 4001 ticks or more, forms no coincidence. An electron that is too young stays stored for later protons.
- R5: Pixels are numbered row by row in axial coordinates (q, r) with |q|, |r| and |q+r| at most 6. Rows run from r = -6 to r = 6, and q rises within each row, starting at index 0. Two pixels match when they are equal or when (dq, dr) is one of (±1, 0), (0, ±1), (1, -1) or (-1, 1). Edge pixels therefore have fewer neighbours.
- R6: When several stored electrons match one proton, the one that arrived first is paired. It is removed, so a later proton cannot pair with it again.
- R7: On every accepted hit, stored electrons whose age relative to that hit's timestamp exceeds 4000 ticks are retired before the hit is stored. The space they free is available to that same hit.
- R8: The store holds 8 electrons. An electron arriving when 8 unexpired entries remain discards the oldest entry and increments `ovf_count` by one.
- R9: After reset, `single_valid`, `coinc_valid` and `ovf_count` are zero and the store is empty.
- R10: Proton hits are never stored, and electron hits never produce a coincidence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_valid | input | 1 | A hit is presented this cycle |
| hit_pixel | input | 7 | Pixel index of the hit |
| hit_time | input | 32 | Hit timestamp in 10 ns ticks |
| hit_is_proton | input | 1 | 1 for proton, 0 for electron |
| single_valid | output | 1 | Single-particle trigger strobe |
| single_pixel | output | 7 | Pixel of the single trigger |
| single_is_proton | output | 1 | Class of the single trigger |
| coinc_valid | output | 1 | Coincidence strobe |
| coinc_e_pixel | output | 7 | Electron pixel of the pair |
| coinc_p_pixel | output | 7 | Proton pixel of the pair |
| coinc_tof | output | 12 | Proton minus electron timestamp, ticks |
| ovf_count | output | 16 | Number of electrons discarded on a full store |

## Verification
The assertions check several properties on every cycle. Each legal hit is echoed on the single-trigger outputs, and an illegal index stays silent. A reported time of flight always lies inside the window. A coincidence only follows a proton hit. The overflow count only steps by one after an electron, and only when the store is full. The bench's behavioural model alone can show which electron a proton is paired with: the earliest in-window neighbour. Only the model can also show that a paired electron is not reused, that retirement frees space before an overflow would occur, and that edge pixels match only across their real neighbours.

// File: rtl/coinc_pkg.sv
package coinc_pkg;

  localparam int AX_W = 5;

  typedef struct packed {
    logic signed [AX_W-1:0] q;
    logic signed [AX_W-1:0] r;
  } axial_t;

  // number of pixels in a hexagon of the given radius
  function automatic int hex_count(input int radius);
    return 3 * radius * (radius + 1) + 1;
  endfunction

  // pixel index -> axial coordinate; rows by r ascending, q ascending in a row
  function automatic axial_t hex_axial(input int idx, input int radius);
    axial_t a;
    int     start;
    int     len;
    int     qmin;
    a     = '0;
    start = 0;
    for (int r = -radius; r <= radius; r++) begin
      qmin = (r < 0) ? (-radius - r) : -radius;
      len  = 2 * radius + 1 - ((r < 0) ? -r : r);
      if (idx >= start && idx < start + len) begin
        a.q = AX_W'(qmin + idx - start);
        a.r = AX_W'(r);
      end
      start = start + len;
    end
    return a;
  endfunction

  // same cell or one of the six axial neighbours
  function automatic logic hex_adjacent(input axial_t a, input axial_t b);
    logic signed [AX_W:0] dq;
    logic signed [AX_W:0] dr;
    dq = {a.q[AX_W-1], a.q} - {b.q[AX_W-1], b.q};
    dr = {a.r[AX_W-1], a.r} - {b.r[AX_W-1], b.r};
    return (dq == 0  && dr == 0)  ||
           (dq == 1  && dr == 0)  || (dq == -1 && dr == 0) ||
           (dq == 0  && dr == 1)  || (dq == 0  && dr == -1) ||
           (dq == 1  && dr == -1) || (dq == -1 && dr == 1);
  endfunction

  function automatic logic age_in_window(input logic [63:0] age, input int lo, input int hi);
    return (age >= 64'(lo)) && (age <= 64'(hi));
  endfunction

  function automatic logic age_expired(input logic [63:0] age, input int hi);
    return age > 64'(hi);
  endfunction

endpackage

// File: rtl/hex_locator.sv
module hex_locator
  import coinc_pkg::*;
#(
  parameter int RADIUS = 6,
  parameter int PIX_W  = 7
) (
  input  logic [PIX_W-1:0] pix,
  output axial_t           crd,
  output logic             in_range
);
  localparam int NPIX = hex_count(RADIUS);

  assign in_range = (int'(pix) < NPIX);
  assign crd      = hex_axial(int'(pix), RADIUS);
endmodule

// File: rtl/slot_judge.sv
module slot_judge
  import coinc_pkg::*;
#(
  parameter int TS_W   = 32,
  parameter int WIN_LO = 1200,
  parameter int WIN_HI = 4000
) (
  input  logic            act,
  input  logic            is_proton,
  input  logic            vld,
  input  logic [TS_W-1:0] now_ts,
  input  logic [TS_W-1:0] ent_ts,
  input  axial_t          now_crd,
  input  axial_t          ent_crd,
  output logic            expired,
  output logic            cand,
  output logic [TS_W-1:0] age
);
  assign age     = now_ts - ent_ts;
  assign expired = act && vld && age_expired(64'(age), WIN_HI);
  assign cand    = act && is_proton && vld &&
                   age_in_window(64'(age), WIN_LO, WIN_HI) &&
                   hex_adjacent(now_crd, ent_crd);
endmodule

// File: rtl/pend_store.sv
module pend_store
  import coinc_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PIX_W = 7,
  parameter int TS_W  = 32,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] kill,
  input  logic             ins_en,
  input  logic [PIX_W-1:0] ins_pix,
  input  logic [TS_W-1:0]  ins_ts,
  input  axial_t           ins_crd,
  output logic [DEPTH-1:0] vld,
  output logic [PIX_W-1:0] ent_pix [DEPTH],
  output logic [TS_W-1:0]  ent_ts  [DEPTH],
  output axial_t           ent_crd [DEPTH],
  output logic [CNT_W-1:0] occ,
  output logic             drop
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] nv;
  logic [PIX_W-1:0] np [DEPTH];
  logic [TS_W-1:0]  nt [DEPTH];
  axial_t           nc [DEPTH];
  logic [CNT_W-1:0] nocc;

  // compact survivors toward slot 0 (oldest), then append the new electron
  always_comb begin
    int kept;
    nv   = '0;
    drop = 1'b0;
    for (int j = 0; j < DEPTH; j++) begin
      np[j] = '0;
      nt[j] = '0;
      nc[j] = '0;
    end
    kept = 0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld[i] && !kill[i]) begin
        np[kept[IDX_W-1:0]] = ent_pix[i];
        nt[kept[IDX_W-1:0]] = ent_ts[i];
        nc[kept[IDX_W-1:0]] = ent_crd[i];
        nv[kept[IDX_W-1:0]] = 1'b1;
        kept = kept + 1;
      end
    end
    if (ins_en) begin
      if (kept == DEPTH) begin
        drop = 1'b1;
        for (int j = 0; j < DEPTH - 1; j++) begin
          np[j] = np[j+1];
          nt[j] = nt[j+1];
          nc[j] = nc[j+1];
        end
        np[DEPTH-1] = ins_pix;
        nt[DEPTH-1] = ins_ts;
        nc[DEPTH-1] = ins_crd;
      end else begin
        np[kept[IDX_W-1:0]] = ins_pix;
        nt[kept[IDX_W-1:0]] = ins_ts;
        nc[kept[IDX_W-1:0]] = ins_crd;
        nv[kept[IDX_W-1:0]] = 1'b1;
        kept = kept + 1;
      end
    end
    nocc = CNT_W'(kept);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      occ <= '0;
      for (int j = 0; j < DEPTH; j++) begin
        ent_pix[j] <= '0;
        ent_ts[j]  <= '0;
        ent_crd[j] <= '0;
      end
    end else begin
      vld <= nv;
      occ <= nocc;
      for (int j = 0; j < DEPTH; j++) begin
        ent_pix[j] <= np[j];
        ent_ts[j]  <= nt[j];
        ent_crd[j] <= nc[j];
      end
    end
  end
endmodule

// File: rtl/coinc_trigger.sv
module coinc_trigger
  import coinc_pkg::*;
#(
  parameter int  HEX_RADIUS = 6,
  parameter int  TS_W       = 32,
  parameter int  DEPTH      = 8,
  parameter int  WIN_LO     = 1200,
  parameter int  WIN_HI     = 4000,
  parameter int  TOF_W      = 12,
  parameter int  OVF_W      = 16,
  localparam int NUM_PIX    = 3 * HEX_RADIUS * (HEX_RADIUS + 1) + 1,
  localparam int PIX_W      = $clog2(NUM_PIX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_valid,
  input  logic [PIX_W-1:0] hit_pixel,
  input  logic [TS_W-1:0]  hit_time,
  input  logic             hit_is_proton,
  output logic             single_valid,
  output logic [PIX_W-1:0] single_pixel,
  output logic             single_is_proton,
  output logic             coinc_valid,
  output logic [PIX_W-1:0] coinc_e_pixel,
  output logic [PIX_W-1:0] coinc_p_pixel,
  output logic [TOF_W-1:0] coinc_tof,
  output logic [OVF_W-1:0] ovf_count
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // named internal events
  logic             pix_ok;
  logic             hit_act;
  axial_t           hit_crd;
  logic             ins_en;
  logic             match_hit;
  logic             drop_evt;
  logic [CNT_W-1:0] occ;
  logic [IDX_W-1:0] sel_idx;
  logic [DEPTH-1:0] sel_oh;
  logic [DEPTH-1:0] expired;
  logic [DEPTH-1:0] cand;
  logic [DEPTH-1:0] kill;
  logic [DEPTH-1:0] vld;
  logic [PIX_W-1:0] ent_pix [DEPTH];
  logic [TS_W-1:0]  ent_ts  [DEPTH];
  axial_t           ent_crd [DEPTH];
  logic [TS_W-1:0]  age     [DEPTH];

  hex_locator #(.RADIUS(HEX_RADIUS), .PIX_W(PIX_W)) u_loc (
    .pix      (hit_pixel),
    .crd      (hit_crd),
    .in_range (pix_ok)
  );

  assign hit_act = hit_valid && pix_ok;
  assign ins_en  = hit_act && !hit_is_proton;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    slot_judge #(.TS_W(TS_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_judge (
      .act       (hit_act),
      .is_proton (hit_is_proton),
      .vld       (vld[g]),
      .now_ts    (hit_time),
      .ent_ts    (ent_ts[g]),
      .now_crd   (hit_crd),
      .ent_crd   (ent_crd[g]),
      .expired   (expired[g]),
      .cand      (cand[g]),
      .age       (age[g])
    );
  end

  // earliest (lowest slot) candidate wins
  always_comb begin
    sel_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (cand[i]) sel_idx = IDX_W'(i);
    end
    match_hit = |cand;
    sel_oh    = '0;
    if (match_hit) sel_oh[sel_idx] = 1'b1;
  end

  assign kill = expired | sel_oh;

  pend_store #(.DEPTH(DEPTH), .PIX_W(PIX_W), .TS_W(TS_W), .CNT_W(CNT_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .kill    (kill),
    .ins_en  (ins_en),
    .ins_pix (hit_pixel),
    .ins_ts  (hit_time),
    .ins_crd (hit_crd),
    .vld     (vld),
    .ent_pix (ent_pix),
    .ent_ts  (ent_ts),
    .ent_crd (ent_crd),
    .occ     (occ),
    .drop    (drop_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      single_valid     <= 1'b0;
      single_pixel     <= '0;
      single_is_proton <= 1'b0;
      coinc_valid      <= 1'b0;
      coinc_e_pixel    <= '0;
      coinc_p_pixel    <= '0;
      coinc_tof        <= '0;
      ovf_count        <= '0;
    end else begin
      single_valid <= hit_act;
      if (hit_act) begin
        single_pixel     <= hit_pixel;
        single_is_proton <= hit_is_proton;
      end
      coinc_valid <= match_hit;
      if (match_hit) begin
        coinc_e_pixel <= ent_pix[sel_idx];
        coinc_p_pixel <= hit_pixel;
        coinc_tof     <= TOF_W'(age[sel_idx]);
      end
      if (drop_evt) ovf_count <= ovf_count + 1'b1;
    end
  end
endmodule

// File: rtl/coinc_trigger_chk.sv
module coinc_trigger_chk #(
  parameter int PIX_W   = 7,
  parameter int NUM_PIX = 127,
  parameter int TS_W    = 32,
  parameter int TOF_W   = 12,
  parameter int OVF_W   = 16,
  parameter int DEPTH   = 8,
  parameter int WIN_LO  = 1200,
  parameter int WIN_HI  = 4000
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         hit_valid,
  input logic [PIX_W-1:0]             hit_pixel,
  input logic                         hit_is_proton,
  input logic                         single_valid,
  input logic [PIX_W-1:0]             single_pixel,
  input logic                         single_is_proton,
  input logic                         coinc_valid,
  input logic [PIX_W-1:0]             coinc_p_pixel,
  input logic [TOF_W-1:0]             coinc_tof,
  input logic [OVF_W-1:0]             ovf_count,
  input logic [$clog2(DEPTH+1)-1:0]   occ,
  input logic                         match_hit,
  input logic                         drop_evt
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  assert_single_echo_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && int'(hit_pixel) < NUM_PIX) |=>
      (single_valid && single_pixel == $past(hit_pixel) &&
       single_is_proton == $past(hit_is_proton)));

  assert_bad_pixel_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && int'(hit_pixel) >= NUM_PIX) |=>
      (!single_valid && !coinc_valid && $stable(ovf_count)));

  assert_tof_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    coinc_valid |-> (int'(coinc_tof) >= WIN_LO && int'(coinc_tof) <= WIN_HI));

  assert_coinc_after_proton_R10: assert property (@(posedge clk) disable iff (!rst_n)
    coinc_valid |-> (single_valid && single_is_proton && coinc_p_pixel == single_pixel));

  assert_match_only_proton_R6: assert property (@(posedge clk) disable iff (!rst_n)
    match_hit |-> (hit_valid && hit_is_proton));

  assert_occ_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CNT_W'(DEPTH));

  assert_drop_only_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |-> (occ == CNT_W'(DEPTH) && hit_valid && !hit_is_proton));

  assert_ovf_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_count != $past(ovf_count)) |->
      (ovf_count == $past(ovf_count) + 1'b1 && $past(hit_valid && !hit_is_proton)));
endmodule

bind coinc_trigger coinc_trigger_chk #(
  .PIX_W(PIX_W), .NUM_PIX(NUM_PIX), .TS_W(TS_W), .TOF_W(TOF_W), .OVF_W(OVF_W),
  .DEPTH(DEPTH), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
) u_chk (.*);

// File: tb/coinc_trigger_test.sv
`timescale 1ns/1ps
module coinc_trigger_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hit_valid = 1'b0;
  logic [6:0]  hit_pixel = '0;
  logic [31:0] hit_time = '0;
  logic        hit_is_proton = 1'b0;
  logic        single_valid, single_is_proton, coinc_valid;
  logic [6:0]  single_pixel, coinc_e_pixel, coinc_p_pixel;
  logic [11:0] coinc_tof;
  logic [15:0] ovf_count;

  always #4 clk = ~clk;

  coinc_trigger uut (
    .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_pixel(hit_pixel),
    .hit_time(hit_time), .hit_is_proton(hit_is_proton),
    .single_valid(single_valid), .single_pixel(single_pixel),
    .single_is_proton(single_is_proton), .coinc_valid(coinc_valid),
    .coinc_e_pixel(coinc_e_pixel), .coinc_p_pixel(coinc_p_pixel),
    .coinc_tof(coinc_tof), .ovf_count(ovf_count)
  );

  typedef struct { int pix; longint ts; } pend_t;
  pend_t  model_q[$];
  int     cq[127];
  int     cr[127];
  longint t_now = 0;
  int     checks = 0;
  int     fails = 0;
  bit     done = 0;
  string  cur_req = "R9";
  bit     exp_sv = 0, exp_sip = 0, exp_cv = 0;
  int     exp_sp = 0, exp_ep = 0, exp_pp = 0, exp_tof = 0, exp_ovf = 0;

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // hex distance of at most one (R5)
  function automatic bit near(input int a, input int b);
    int dq, dr, m;
    dq = cq[a] - cq[b];
    dr = cr[a] - cr[b];
    m = iabs(dq);
    if (iabs(dr) > m) m = iabs(dr);
    if (iabs(dq + dr) > m) m = iabs(dq + dr);
    return m <= 1;
  endfunction

  task automatic cmp(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
    end
  endtask

  task automatic compare_outputs();
    cmp("single_valid", 64'(single_valid), 64'(exp_sv));
    if (exp_sv) begin
      cmp("single_pixel", 64'(single_pixel), 64'(exp_sp));
      cmp("single_is_proton", 64'(single_is_proton), 64'(exp_sip));
    end
    cmp("coinc_valid", 64'(coinc_valid), 64'(exp_cv));
    if (exp_cv) begin
      cmp("coinc_e_pixel", 64'(coinc_e_pixel), 64'(exp_ep));
      cmp("coinc_p_pixel", 64'(coinc_p_pixel), 64'(exp_pp));
      cmp("coinc_tof", 64'(coinc_tof), 64'(exp_tof));
    end
    cmp("ovf_count", 64'(ovf_count), 64'(exp_ovf));
  endtask

  // one cycle: check last cycle's results, present a hit, update the model
  task automatic step(input bit v, input int pix, input bit isp, input int dt);
    @(negedge clk);
    compare_outputs();
    t_now += dt;
    hit_valid     = v;
    hit_pixel     = 7'(pix);
    hit_is_proton = isp;
    hit_time      = 32'(t_now);
    exp_sv = 0;
    exp_cv = 0;
    if (v && pix < 127) begin
      exp_sv  = 1;
      exp_sp  = pix;
      exp_sip = isp;
      for (int i = model_q.size() - 1; i >= 0; i--)
        if (t_now - model_q[i].ts > 4000) model_q.delete(i);
      if (isp) begin
        for (int i = 0; i < model_q.size(); i++) begin
          longint a = t_now - model_q[i].ts;
          if (a >= 1200 && a <= 4000 && near(pix, model_q[i].pix)) begin
            exp_cv  = 1;
            exp_ep  = model_q[i].pix;
            exp_pp  = pix;
            exp_tof = int'(a);
            model_q.delete(i);
            break;
          end
        end
      end else begin
        pend_t e;
        if (model_q.size() == 8) begin
          void'(model_q.pop_front());
          exp_ovf++;
        end
        e.pix = pix;
        e.ts  = t_now;
        model_q.push_back(e);
      end
    end
  endtask

  task automatic hit(input int pix, input bit isp, input int dt);
    step(1'b1, pix, isp, dt);
  endtask

  task automatic idle();
    step(1'b0, 0, 1'b0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int idx = 0;
    for (int r = -6; r <= 6; r++)
      for (int q = -6; q <= 6; q++)
        if (iabs(q + r) <= 6) begin
          cq[idx] = q;
          cr[idx] = r;
          idx++;
        end

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9: reset state visible before any hit
    cur_req = "R9";
    idle(); idle();

    // R1: singles for both classes
    cur_req = "R1";
    hit(10, 1'b0, 5000); hit(100, 1'b1, 3); hit(126, 1'b0, 3); hit(0, 1'b1, 3);
    idle();

    // R3: window bounds inclusive
    cur_req = "R3";
    hit(60, 1'b0, 5000); hit(60, 1'b1, 1200);
    hit(63, 1'b0, 5000); hit(64, 1'b1, 4000);
    idle();

    // R4: one tick outside on each side, young electron kept
    cur_req = "R4";
    hit(40, 1'b0, 5000); hit(40, 1'b1, 1199); hit(40, 1'b1, 2802);
    hit(41, 1'b0, 5000); hit(41, 1'b1, 1500); hit(41, 1'b1, 2501);
    idle();

    // R5: edge pixels and index neighbours on different rows
    cur_req = "R5";
    hit(6, 1'b0, 5000);  hit(7, 1'b1, 1300);  hit(14, 1'b1, 10);
    hit(0, 1'b0, 5000);  hit(2, 1'b1, 1300);  hit(8, 1'b1, 10);
    hit(63, 1'b0, 5000); hit(76, 1'b1, 1300); hit(65, 1'b1, 10); hit(71, 1'b1, 10);
    idle();

    // R6: earliest paired first, then removed
    cur_req = "R6";
    hit(63, 1'b0, 5000); hit(63, 1'b0, 10);
    hit(63, 1'b1, 1990); hit(63, 1'b1, 5); hit(63, 1'b1, 5);
    idle();

    // R2: illegal index ignored, stored electron untouched
    cur_req = "R2";
    hit(50, 1'b0, 5000); hit(127, 1'b1, 1500); hit(127, 1'b0, 1);
    hit(50, 1'b1, 1);
    idle();

    // R10: proton never stored, electron never pairs
    cur_req = "R10";
    hit(30, 1'b1, 5000); hit(30, 1'b0, 2000); hit(30, 1'b0, 1300);
    idle();

    // R8: overflow on full store
    cur_req = "R8";
    for (int k = 0; k < 10; k++) hit(20, 1'b0, (k == 0) ? 5000 : 1);
    hit(20, 1'b1, 1300);
    idle();

    // R7: retirement frees space before a would-be overflow
    cur_req = "R7";
    for (int k = 0; k < 8; k++) hit(90, 1'b0, (k == 0) ? 5000 : 1);
    hit(91, 1'b0, 4001);
    for (int k = 0; k < 7; k++) hit(92, 1'b0, 1);
    hit(92, 1'b0, 1);
    idle();

    // mixed traffic around a small cluster
    cur_req = "R3";
    void'($urandom(7));
    for (int k = 0; k < 600; k++) begin
      int pix = 58 + int'($urandom % 10);
      if ($urandom % 25 == 0) pix = 127;
      hit(pix, 1'($urandom % 2), int'($urandom % 700));
    end
    idle(); idle();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule